// File: doc/BRIEF.md
# Byte Service-Request Flag and Clock-Hold Controller

This block sits beside the bit shifter and bus monitor of a multi-master I2C controller. It keeps the active-low service-request flag that tells software a byte needs attention, and it decides whether SCL is held low while software does that work. The shifter and monitor send it single-cycle event strobes: address phase finished, byte sent, falling edge of the 8th SCL clock, falling edge of the ACK clock, and arbitration lost. The block also takes the received 7-bit address, three programmable own addresses, the mode and configuration bits, and strobes for writes to the data and control registers.

The point at which a received byte counts as complete can be set to the 8th clock edge or to the ACK clock edge. An early-wait option raises the request as soon as eight data bits are in, and arms an internal wait flag that a later control-register write can release. In slave-receive mode the address is matched against the three own addresses and the general-call address. Free format skips that comparison. When the block loses arbitration to an address that is not its own, it sets the flag but does not hold SCL.

The outputs are the flag, a one-cycle interrupt pulse on each new request, the SCL hold request, and two registered match results that the slave logic uses to decide whether to acknowledge.

Top module: `svcreq_hold_ctrl`

## Requirements
- R1: After synchronous reset, `req_n` is 1 and `irq_pulse`, `scl_hold`, `addr_hit` and `gc_hit` are all 0.
- R2: In master mode (`mode_sel[1]`=1), an `ev_addr_done` strobe drives `req_n` to 0. In any mode, an `ev_tx_done` strobe drives `req_n` to 0. Both hold when `ev_arb_lost` comes in the same cycle.
- R3: While `byte_rx`=1, a received byte completes on `ev_fall8` when `cfg_ack_late`=0 and on `ev_ack_fall` when `cfg_ack_late`=1. When `cfg_early_wait`=0, the other edge has no effect on `req_n`.
- R4: With `cfg_early_wait`=1 and `byte_rx`=1, `ev_fall8` drives `req_n` to 0 whatever the setting of `cfg_ack_late`, and it arms the internal wait flag.
- R5: In slave-receive mode (`mode_sel`=2'b00) with `cfg_free_fmt`=0, `ev_addr_done` drives `req_n` to 0 only when `rx_addr` equals one of the three own addresses or equals 7'b0000000. `addr_hit` (own match) and `gc_hit` (general call) are 1 for exactly the cycle after the strobe. `ev_addr_done` in slave-transmit mode (`mode_sel`=2'b01) has no effect on `req_n`.
- R6: In slave-receive mode with `cfg_free_fmt`=1, `ev_addr_done` drives `req_n` to 0 without any address comparison.
- R7: `irq_pulse` is 1 in exactly the cycle in which `req_n` goes from 1 to 0, and is 0 in every other cycle.
- R8: `wr_data` returns `req_n` to 1. `wr_ctrl` returns `req_n` to 1 and clears the wait flag only when `cfg_early_wait`=1 and the wait flag is armed. In any other case `wr_ctrl` has no effect.
- R9: `scl_hold` is 1 while `req_n` is 0. The exception is a request raised in master mode with `ev_arb_lost`, `cfg_free_fmt`=0, and an `rx_addr` that matches neither an own address nor general call. In that case `scl_hold` stays 0.
- R10: `cfg_enable`=0 or `cfg_ifrst`=1 forces `req_n` to 1, `scl_hold` to 0 and `irq_pulse` to 0, and disarms the wait flag. This overrides any event in the same cycle.
- R11: When a request event and a `wr_data` or `wr_ctrl` clear land in the same cycle, the request wins: `req_n` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Interface enable |
| cfg_ifrst | input | 1 | Interface soft reset |
| cfg_ack_late | input | 1 | 1: byte completes on the ACK clock edge, 0: on the 8th clock edge |
| cfg_early_wait | input | 1 | Raise the request after 8 bits and arm the wait flag |
| cfg_free_fmt | input | 1 | 1: free format, no address comparison |
| mode_sel | input | 2 | bit1 = master, bit0 = transmitter |
| ev_addr_done | input | 1 | Address phase finished strobe |
| ev_tx_done | input | 1 | Byte transmitted strobe |
| ev_fall8 | input | 1 | Falling edge of 8th SCL clock strobe |
| ev_ack_fall | input | 1 | Falling edge of ACK clock strobe |
| ev_arb_lost | input | 1 | Arbitration lost strobe |
| byte_rx | input | 1 | Current data byte is being received |
| rx_addr | input | ADDR_W | Received 7-bit address |
| own_addr_flat | input | NUM_OWN*ADDR_W | Own addresses, entry i at bits i*ADDR_W |
| wr_data | input | 1 | Data register write strobe |
| wr_ctrl | input | 1 | Control register write strobe |
| req_n | output | 1 | Service-request flag, 0 = pending |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| scl_hold | output | 1 | Request to hold SCL low |
| addr_hit | output | 1 | Own-address match, valid the cycle after ev_addr_done |
| gc_hit | output | 1 | General-call match, valid the cycle after ev_addr_done |

## Verification
A request event and a software clear can arrive in the same cycle. So can a request event and a disable or soft reset. The bench drives `ev_tx_done` in the same cycle as `wr_data`, and expects the flag low with an interrupt pulse. It drives the same strobe in the same cycle as `cfg_ifrst`, and expects the flag to stay high with no pulse. A further pair checks that a control write after a soft reset has no effect, because the soft reset disarmed the wait flag.

// File: rtl/svc_pkg.sv
package svc_pkg;

    typedef enum logic [1:0] {
        MODE_SLV_RX = 2'b00,
        MODE_SLV_TX = 2'b01,
        MODE_MST_RX = 2'b10,
        MODE_MST_TX = 2'b11
    } mode_e;

    typedef struct packed {
        logic enable;
        logic ifrst;
        logic ack_late;
        logic early_wait;
        logic free_fmt;
    } cfg_t;

    typedef struct packed {
        logic addr_done;
        logic tx_done;
        logic fall8;
        logic ack_fall;
        logic arb_lost;
        logic byte_rx;
    } ev_t;

    typedef struct packed {
        logic set;
        logic arm_wait;
        logic release_scl;
    } setreq_t;

    function automatic logic mode_is_master(mode_e m);
        return m[1];
    endfunction

    function automatic logic cfg_kill(cfg_t c);
        return !c.enable || c.ifrst;
    endfunction

endpackage

// File: rtl/svc_addr_match.sv
module svc_addr_match #(
    parameter int ADDR_W  = 7,
    parameter int NUM_OWN = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      kill,
    input  logic                      addr_done,
    input  logic [ADDR_W-1:0]         rx_addr,
    input  logic [NUM_OWN*ADDR_W-1:0] own_flat,
    output logic                      own_hit_now,
    output logic                      gc_hit_now,
    output logic                      own_hit_q,
    output logic                      gc_hit_q
);
    logic [NUM_OWN-1:0] hit_vec;

    for (genvar i = 0; i < NUM_OWN; i++) begin : g_cmp
        assign hit_vec[i] = (rx_addr == own_flat[i*ADDR_W +: ADDR_W]);
    end

    assign own_hit_now = |hit_vec;
    assign gc_hit_now  = (rx_addr == '0);

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            own_hit_q <= 1'b0;
            gc_hit_q  <= 1'b0;
        end else begin
            own_hit_q <= addr_done && own_hit_now;
            gc_hit_q  <= addr_done && gc_hit_now;
        end
    end
endmodule

// File: rtl/svc_event_decode.sv
module svc_event_decode
    import svc_pkg::*;
(
    input  cfg_t        cfg,
    input  ev_t         ev,
    input  logic [1:0]  mode,
    input  logic        own_hit,
    input  logic        gc_hit,
    output setreq_t     sr
);
    mode_e m;
    logic  master;
    logic  any_hit;
    logic  addr_set;
    logic  rx_point;
    logic  rx_set;
    logic  ew_set;

    always_comb begin
        m        = mode_e'(mode);
        master   = mode_is_master(m);
        any_hit  = own_hit || gc_hit;
        addr_set = ev.addr_done &&
                   (master || (m == MODE_SLV_RX && (cfg.free_fmt || any_hit)));
        rx_point = cfg.ack_late ? ev.ack_fall : ev.fall8;
        rx_set   = ev.byte_rx && rx_point;
        ew_set   = ev.byte_rx && cfg.early_wait && ev.fall8;

        sr.set         = addr_set || ev.tx_done || rx_set || ew_set;
        sr.arm_wait    = ew_set;
        sr.release_scl = master && ev.arb_lost && !cfg.free_fmt && !any_hit &&
                         (ev.addr_done || ev.tx_done);
    end
endmodule

// File: rtl/svc_flag_core.sv
module svc_flag_core
    import svc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    kill,
    input  setreq_t sr,
    input  logic    wr_data,
    input  logic    wr_ctrl,
    input  logic    early_wait,
    output logic    req_n,
    output logic    irq_pulse,
    output logic    scl_hold
);
    logic req_q;
    logic wait_q;
    logic rel_q;
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            req_q  <= 1'b1;
            wait_q <= 1'b0;
            rel_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= sr.set && req_q;
            if (sr.set) begin
                req_q <= 1'b0;
                rel_q <= sr.release_scl;
                if (sr.arm_wait) begin
                    wait_q <= 1'b1;
                end
            end else if (wr_data) begin
                req_q <= 1'b1;
                rel_q <= 1'b0;
            end else if (wr_ctrl && early_wait && wait_q) begin
                req_q  <= 1'b1;
                wait_q <= 1'b0;
                rel_q  <= 1'b0;
            end
        end
    end

    assign req_n     = req_q;
    assign irq_pulse = irq_q;
    assign scl_hold  = !req_q && !rel_q;
endmodule

// File: rtl/svcreq_hold_ctrl.sv
module svcreq_hold_ctrl
    import svc_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int NUM_OWN = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_enable,
    input  logic                      cfg_ifrst,
    input  logic                      cfg_ack_late,
    input  logic                      cfg_early_wait,
    input  logic                      cfg_free_fmt,
    input  logic [1:0]                mode_sel,
    input  logic                      ev_addr_done,
    input  logic                      ev_tx_done,
    input  logic                      ev_fall8,
    input  logic                      ev_ack_fall,
    input  logic                      ev_arb_lost,
    input  logic                      byte_rx,
    input  logic [ADDR_W-1:0]         rx_addr,
    input  logic [NUM_OWN*ADDR_W-1:0] own_addr_flat,
    input  logic                      wr_data,
    input  logic                      wr_ctrl,
    output logic                      req_n,
    output logic                      irq_pulse,
    output logic                      scl_hold,
    output logic                      addr_hit,
    output logic                      gc_hit
);
    cfg_t    cfg;
    ev_t     ev;
    setreq_t sr;
    logic    kill;
    logic    own_now;
    logic    gc_now;

    always_comb begin
        cfg.enable     = cfg_enable;
        cfg.ifrst      = cfg_ifrst;
        cfg.ack_late   = cfg_ack_late;
        cfg.early_wait = cfg_early_wait;
        cfg.free_fmt   = cfg_free_fmt;
        ev.addr_done   = ev_addr_done;
        ev.tx_done     = ev_tx_done;
        ev.fall8       = ev_fall8;
        ev.ack_fall    = ev_ack_fall;
        ev.arb_lost    = ev_arb_lost;
        ev.byte_rx     = byte_rx;
        kill           = cfg_kill(cfg);
    end

    svc_addr_match #(.ADDR_W(ADDR_W), .NUM_OWN(NUM_OWN)) u_match (
        .clk        (clk),
        .rst        (rst),
        .kill       (kill),
        .addr_done  (ev_addr_done),
        .rx_addr    (rx_addr),
        .own_flat   (own_addr_flat),
        .own_hit_now(own_now),
        .gc_hit_now (gc_now),
        .own_hit_q  (addr_hit),
        .gc_hit_q   (gc_hit)
    );

    svc_event_decode u_dec (
        .cfg    (cfg),
        .ev     (ev),
        .mode   (mode_sel),
        .own_hit(own_now),
        .gc_hit (gc_now),
        .sr     (sr)
    );

    svc_flag_core u_core (
        .clk       (clk),
        .rst       (rst),
        .kill      (kill),
        .sr        (sr),
        .wr_data   (wr_data),
        .wr_ctrl   (wr_ctrl),
        .early_wait(cfg_early_wait),
        .req_n     (req_n),
        .irq_pulse (irq_pulse),
        .scl_hold  (scl_hold)
    );
endmodule

// File: rtl/svc_checker.sv
module svc_checker (
    input logic clk,
    input logic rst,
    input logic cfg_enable,
    input logic cfg_ifrst,
    input logic ev_addr_done,
    input logic ev_tx_done,
    input logic ev_fall8,
    input logic ev_ack_fall,
    input logic wr_data,
    input logic req_n,
    input logic irq_pulse,
    input logic scl_hold,
    input logic addr_hit,
    input logic gc_hit
);
    // R7: a pulse only accompanies a fresh request
    a_r7_pulse_on_fall: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (!req_n && $past(req_n)));

    // R7: every new request is announced
    a_r7_fall_has_pulse: assert property (@(posedge clk) disable iff (rst)
        $fell(req_n) |-> irq_pulse);

    // R9: no hold without a pending request
    a_r9_hold_needs_req: assert property (@(posedge clk) disable iff (rst)
        scl_hold |-> !req_n);

    // R10: disable or soft reset wins over everything
    a_r10_kill_clears: assert property (@(posedge clk) disable iff (rst)
        (!cfg_enable || cfg_ifrst) |=> (req_n && !scl_hold && !irq_pulse));

    // R8: data write with no event releases the flag
    a_r8_data_write_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !ev_addr_done && !ev_tx_done && !ev_fall8 && !ev_ack_fall)
        |=> req_n);

    // R5: match outputs only follow an address strobe
    a_r5_hit_after_strobe: assert property (@(posedge clk) disable iff (rst)
        (addr_hit || gc_hit) |-> $past(ev_addr_done));
endmodule

bind svcreq_hold_ctrl svc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_enable  (cfg_enable),
    .cfg_ifrst   (cfg_ifrst),
    .ev_addr_done(ev_addr_done),
    .ev_tx_done  (ev_tx_done),
    .ev_fall8    (ev_fall8),
    .ev_ack_fall (ev_ack_fall),
    .wr_data     (wr_data),
    .req_n       (req_n),
    .irq_pulse   (irq_pulse),
    .scl_hold    (scl_hold),
    .addr_hit    (addr_hit),
    .gc_hit      (gc_hit)
);

// File: tb/sim_svcreq_hold_ctrl.sv
`timescale 1ns/1ps
module sim_svcreq_hold_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_enable = 1'b1, cfg_ifrst = 1'b0, cfg_ack_late = 1'b0;
    logic cfg_early_wait = 1'b0, cfg_free_fmt = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic ev_addr_done = 1'b0, ev_tx_done = 1'b0, ev_fall8 = 1'b0;
    logic ev_ack_fall = 1'b0, ev_arb_lost = 1'b0, byte_rx = 1'b0;
    logic [6:0] rx_addr = 7'h10;
    logic [20:0] own_addr_flat = {7'h55, 7'h3A, 7'h21};
    logic wr_data = 1'b0, wr_ctrl = 1'b0;
    logic req_n, irq_pulse, scl_hold, addr_hit, gc_hit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    svcreq_hold_ctrl u0 (.*);

    task automatic chk(string req, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        ev_addr_done = 0; ev_tx_done = 0; ev_fall8 = 0; ev_ack_fall = 0;
        ev_arb_lost = 0; wr_data = 0; wr_ctrl = 0;
    endtask

    task automatic clear_flag();
        wr_data = 1; step();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1", "req_n", req_n, 1'b1);
        chk("R1", "irq_pulse", irq_pulse, 1'b0);
        chk("R1", "scl_hold", scl_hold, 1'b0);
        chk("R1", "addr_hit", addr_hit, 1'b0);
        chk("R1", "gc_hit", gc_hit, 1'b0);
    endtask

    task automatic t_master_events();
        mode_sel = 2'b11;
        ev_addr_done = 1; step();
        chk("R2", "master addr req_n", req_n, 1'b0);
        chk("R7", "pulse on fall", irq_pulse, 1'b1);
        chk("R9", "hold while pending", scl_hold, 1'b1);
        step();
        chk("R7", "pulse one cycle", irq_pulse, 1'b0);
        clear_flag();
        chk("R8", "data write clears", req_n, 1'b1);
        rx_addr = 7'h21;
        ev_tx_done = 1; ev_arb_lost = 1; step();
        chk("R2", "tx done with arb lost", req_n, 1'b0);
        chk("R9", "hold on own-addr loss", scl_hold, 1'b1);
        clear_flag();
    endtask

    task automatic t_rx_points();
        mode_sel = 2'b00; byte_rx = 1; cfg_ack_late = 0;
        ev_ack_fall = 1; step();
        chk("R3", "ack edge ignored when late=0", req_n, 1'b1);
        ev_fall8 = 1; step();
        chk("R3", "8th edge completes", req_n, 1'b0);
        clear_flag();
        cfg_ack_late = 1;
        ev_fall8 = 1; step();
        chk("R3", "8th edge ignored when late=1", req_n, 1'b1);
        ev_ack_fall = 1; step();
        chk("R3", "ack edge completes", req_n, 1'b0);
        clear_flag();
    endtask

    task automatic t_early_wait();
        cfg_ack_late = 1; cfg_early_wait = 1; byte_rx = 1;
        ev_fall8 = 1; step();
        chk("R4", "early wait req_n", req_n, 1'b0);
        chk("R4", "early wait pulse", irq_pulse, 1'b1);
        wr_ctrl = 1; step();
        chk("R8", "ctrl write releases armed wait", req_n, 1'b1);
        ev_tx_done = 1; step();
        wr_ctrl = 1; step();
        chk("R8", "ctrl write after wait disarmed", req_n, 1'b0);
        clear_flag();
        cfg_early_wait = 0; cfg_ack_late = 0; byte_rx = 0;
    endtask

    task automatic t_slave_match();
        mode_sel = 2'b00; cfg_free_fmt = 0;
        rx_addr = 7'h10; ev_addr_done = 1; step();
        chk("R5", "no match keeps req_n", req_n, 1'b1);
        chk("R5", "no match addr_hit", addr_hit, 1'b0);
        rx_addr = 7'h3A; ev_addr_done = 1; step();
        chk("R5", "own match req_n", req_n, 1'b0);
        chk("R5", "own match addr_hit", addr_hit, 1'b1);
        chk("R5", "own match gc_hit", gc_hit, 1'b0);
        step();
        chk("R5", "addr_hit one cycle", addr_hit, 1'b0);
        clear_flag();
        rx_addr = 7'h00; ev_addr_done = 1; step();
        chk("R5", "general call req_n", req_n, 1'b0);
        chk("R5", "general call gc_hit", gc_hit, 1'b1);
        clear_flag();
        mode_sel = 2'b01; rx_addr = 7'h55; ev_addr_done = 1; step();
        chk("R5", "slave tx addr ignored", req_n, 1'b1);
        mode_sel = 2'b00;
    endtask

    task automatic t_free_fmt();
        cfg_free_fmt = 1; rx_addr = 7'h10;
        ev_addr_done = 1; step();
        chk("R6", "free format req_n", req_n, 1'b0);
        clear_flag();
        cfg_free_fmt = 0;
    endtask

    task automatic t_hold_release();
        mode_sel = 2'b11; rx_addr = 7'h10;
        ev_addr_done = 1; ev_arb_lost = 1; step();
        chk("R9", "lost to stranger req_n", req_n, 1'b0);
        chk("R9", "lost to stranger no hold", scl_hold, 1'b0);
        chk("R7", "lost to stranger pulse", irq_pulse, 1'b1);
        clear_flag();
        rx_addr = 7'h55; ev_addr_done = 1; ev_arb_lost = 1; step();
        chk("R9", "lost to own addr hold", scl_hold, 1'b1);
        clear_flag();
        cfg_free_fmt = 1; rx_addr = 7'h10;
        ev_addr_done = 1; ev_arb_lost = 1; step();
        chk("R9", "free format loss hold", scl_hold, 1'b1);
        clear_flag();
        cfg_free_fmt = 0;
    endtask

    task automatic t_kill();
        mode_sel = 2'b11;
        ev_tx_done = 1; cfg_ifrst = 1; step();
        chk("R10", "ifrst beats event", req_n, 1'b1);
        chk("R10", "ifrst no pulse", irq_pulse, 1'b0);
        cfg_ifrst = 0;
        ev_tx_done = 1; step();
        cfg_enable = 0; step();
        chk("R10", "disable clears req_n", req_n, 1'b1);
        chk("R10", "disable clears hold", scl_hold, 1'b0);
        cfg_enable = 1;
        cfg_early_wait = 1; byte_rx = 1;
        ev_fall8 = 1; step();
        cfg_ifrst = 1; step();
        cfg_ifrst = 0;
        ev_tx_done = 1; step();
        wr_ctrl = 1; step();
        chk("R10", "ifrst disarmed wait", req_n, 1'b0);
        clear_flag();
        cfg_early_wait = 0; byte_rx = 0;
    endtask

    task automatic t_collision();
        mode_sel = 2'b11;
        ev_tx_done = 1; wr_data = 1; step();
        chk("R11", "set beats data write", req_n, 1'b0);
        chk("R11", "set beats write pulse", irq_pulse, 1'b1);
        clear_flag();
    endtask

    initial begin
        t_reset();
        t_master_events();
        t_rx_points();
        t_early_wait();
        t_slave_match();
        t_free_fmt();
        t_hold_release();
        t_kill();
        t_collision();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule